// File: doc/BRIEF.md
# Dithered Digital Pulse-Width Modulator

This block drives the gate of a switching regulator. The switching period is a fixed number of counter clocks. A duty command word holds a whole-tick part and a fractional part. The whole-tick part sets how many clocks the gate stays high in each period.

The fractional part gives a finer average duty than one counter tick, without a faster clock. In a chosen subset of every group of m consecutive periods, the pulse is widened by one tick. The regulator's output filter averages the pulse train, so the fraction shows up as a fraction of a tick in the average. The default is m = 4, which gives quarter-tick steps.

The widened periods are spread out by a fractional accumulator. A period-start strobe marks the first clock of every period. The duty command is taken in only at that boundary.

Top module: `dithered_pwm`

## Requirements
- R1: While running, a period lasts exactly 2^CNT_W clocks (64 by default). `periodStrobe` is high for exactly one clock per period: the first clock of that period.
- R2: In each period, `pwmOut` is high from the first clock of the period for E clocks and low for the rest of it. E is that period's effective compare value. `pwmOut` only rises at a period start.
- R3: The duty word is split into two fields. The integer field is `duty[CNT_W+FRAC_W:FRAC_W]`. The fraction f is `duty[FRAC_W-1:0]`. E equals the integer field plus one in a widened period, and the integer field otherwise.
- R4: A FRAC_W-bit accumulator starts at zero. At each period start it is replaced by (acc + f) mod 2^FRAC_W. The period is widened when that addition carries out. With m = 4 this gives: f=1 widens period 4 of each group; f=2 widens periods 2 and 4; f=3 widens periods 2, 3 and 4. So exactly f of every 4 periods are widened.
- R5: A period whose E is zero keeps `pwmOut` low for the whole period.
- R6: A period whose E is 2^CNT_W or more keeps `pwmOut` high for the whole period.
- R7: `duty` is sampled only at the clock edge that starts a period. A change during a period does not alter that period's pulse.
- R8: While reset is asserted, or from the first clock edge at which `enable` is sampled low, `pwmOut` and `periodStrobe` are low. The counter and the accumulator are cleared, so the next enable starts a fresh dither cycle.
- R9: The clock edge that first samples `enable` high starts a period. `periodStrobe` is high in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the modulator when high |
| duty | input | CNT_W+FRAC_W+1 | Duty command: integer field above fraction field |
| pwmOut | output | 1 | Gate drive |
| periodStrobe | output | 1 | One-clock marker of each period start |

## Verification
The assertions assume that `enable` and `duty` change only between clock edges. They also assume that the value of `duty` sampled at a period-start edge is the command for that period. This is why they compare the first cycle of a period with the `duty` value from the previous edge. The stimulus changes every input on the falling clock edge and holds it there. Each dither pattern is measured from a fresh enable, so the accumulator starts at zero and the widened positions are fixed.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic run;    // modulator active
    logic load;   // start a new period: latch command, step accumulator
    logic clear;  // idle: zero counter, accumulator and compare
  } dpwm_ctrl_t;
endpackage

// File: rtl/dpwm_ctrl.sv
module dpwm_ctrl
  import dpwm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       wrapNow,
  output dpwm_ctrl_t ctrl
);
  logic active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        active <= 1'b0;
    else if (!enable) active <= 1'b0;
    else              active <= 1'b1;
  end

  always_comb begin
    ctrl.run   = active;
    ctrl.clear = !enable;
    ctrl.load  = enable && (!active || wrapNow);
  end
endmodule

// File: rtl/dpwm_datapath.sv
module dpwm_datapath
  import dpwm_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int FRAC_W = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpwm_ctrl_t              ctrl,
  input  logic [CNT_W+FRAC_W:0]   duty,
  output logic                    wrapNow,
  output logic                    pwmOut,
  output logic                    periodStrobe
);
  localparam int INT_W = CNT_W + 1;
  localparam int EFF_W = CNT_W + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic [EFF_W-1:0] effCmp;
  logic [INT_W-1:0] intPart;
  logic             carry;

  assign intPart = duty[CNT_W+FRAC_W:FRAC_W];

  generate
    if (FRAC_W > 0) begin : g_dither
      logic [FRAC_W-1:0] acc;
      logic [FRAC_W:0]   sum;
      assign sum   = {1'b0, acc} + {1'b0, duty[FRAC_W-1:0]};
      assign carry = sum[FRAC_W];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           acc <= '0;
        else if (ctrl.clear) acc <= '0;
        else if (ctrl.load)  acc <= sum[FRAC_W-1:0];
      end
    end else begin : g_plain
      assign carry = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      effCmp <= '0;
    end else if (ctrl.clear) begin
      cnt    <= '0;
      effCmp <= '0;
    end else if (ctrl.load) begin
      cnt    <= '0;
      effCmp <= {1'b0, intPart} + EFF_W'(carry);
    end else if (ctrl.run) begin
      cnt    <= cnt + 1'b1;
    end
  end

  assign wrapNow      = (cnt == CNT_MAX);
  assign pwmOut       = ctrl.run && ({2'b00, cnt} < effCmp);
  assign periodStrobe = ctrl.run && (cnt == '0);
endmodule

// File: rtl/dithered_pwm.sv
module dithered_pwm
  import dpwm_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int FRAC_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enable,
  input  logic [CNT_W+FRAC_W:0] duty,
  output logic                  pwmOut,
  output logic                  periodStrobe
);
  dpwm_ctrl_t ctrl;
  logic       wrapNow;

  dpwm_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .wrapNow (wrapNow),
    .ctrl    (ctrl)
  );

  dpwm_datapath #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .duty         (duty),
    .wrapNow      (wrapNow),
    .pwmOut       (pwmOut),
    .periodStrobe (periodStrobe)
  );
endmodule

// File: rtl/dpwm_checker.sv
module dpwm_checker #(
  parameter int CNT_W  = 6,
  parameter int FRAC_W = 2
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  enable,
  input logic [CNT_W+FRAC_W:0] duty,
  input logic                  pwmOut,
  input logic                  periodStrobe
);
  // R1
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodStrobe |=> !periodStrobe);

  // R2
  rise_at_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmOut) |-> periodStrobe);

  // R5
  zero_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (periodStrobe && $past(duty) == '0) |-> !pwmOut);

  // R6
  full_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (periodStrobe && $past(duty[CNT_W+FRAC_W])) |-> pwmOut);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!pwmOut && !periodStrobe));
endmodule

bind dithered_pwm dpwm_checker #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .enable       (enable),
  .duty         (duty),
  .pwmOut       (pwmOut),
  .periodStrobe (periodStrobe)
);

// File: tb/dithered_pwm_tb.sv
module dithered_pwm_tb;
  localparam int CNT_W  = 6;
  localparam int FRAC_W = 2;
  localparam int PERIOD = 1 << CNT_W;
  localparam int NV     = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [CNT_W+FRAC_W:0] duty = '0;
  logic pwmOut, periodStrobe;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  dithered_pwm #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .duty(duty),
    .pwmOut(pwmOut), .periodStrobe(periodStrobe)
  );

  // duty = {integer field, 2-bit fraction}; expected high clocks for periods 1..4
  localparam logic [8:0] CMD_V [NV] = '{9'd0, 9'd41, 9'd42, 9'd83,
                                        9'd254, 9'd256, 9'd403, 9'd3};
  localparam int EXP_V [NV][4] = '{
    '{0, 0, 0, 0},      // R5: zero command
    '{10, 10, 10, 11},  // R4: int 10, f=1
    '{10, 11, 10, 11},  // R4: int 10, f=2
    '{20, 21, 21, 21},  // R4: int 20, f=3
    '{63, 64, 63, 64},  // R6: widening reaches full scale
    '{64, 64, 64, 64},  // R6: exactly full scale
    '{64, 64, 64, 64},  // R6: above full scale
    '{0, 1, 1, 1}       // R3: widening from zero
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Measures one period starting at the current (or next) strobe sample;
  // optionally changes duty part-way through. Leaves time at the next period's first sample.
  task automatic measure(output int highs, output int strobes,
                         input int changeAt, input logic [8:0] newCmd);
    while (!periodStrobe) @(negedge clk);
    highs = 0;
    strobes = 0;
    for (int i = 0; i < PERIOD; i++) begin
      if (i > 0) @(negedge clk);
      if (i == changeAt) duty = newCmd;
      highs += int'(pwmOut);
      strobes += int'(periodStrobe);
    end
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    int h, s;
    // reset state, R8
    enable = 1'b1;
    duty = 9'd256;
    repeat (3) @(negedge clk);
    check(!pwmOut && !periodStrobe, "R8 reset", int'({pwmOut, periodStrobe}), 0);
    enable = 1'b0;
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(!pwmOut && !periodStrobe, "R8 idle", int'({pwmOut, periodStrobe}), 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      enable = 1'b0;
      repeat (3) @(negedge clk);
      duty = CMD_V[v];
      enable = 1'b1;
      @(negedge clk);
      check(periodStrobe == 1'b1, "R9 start strobe", int'(periodStrobe), 1);
      for (int p = 0; p < 4; p++) begin
        measure(h, s, -1, '0);
        check(h == EXP_V[v][p], "R2 R3 R4 high clocks", h, EXP_V[v][p]);
        check(s == 1 && periodStrobe, "R1 period length", s, 1);
      end
      // pattern repeats after m periods
      measure(h, s, -1, '0);
      check(h == EXP_V[v][0], "R4 repeat", h, EXP_V[v][0]);
    end

    // R7: mid-period change
    enable = 1'b0;
    repeat (3) @(negedge clk);
    duty = 9'd41;
    enable = 1'b1;
    @(negedge clk);
    measure(h, s, 5, 9'd403);
    check(h == 10, "R7 mid-period change", h, 10);
    measure(h, s, -1, '0);
    check(h == 64, "R7 new command next period", h, 64);

    // R8: enable drop mid-period with full-high command
    repeat (20) @(negedge clk);
    check(pwmOut == 1'b1, "R6 high before drop", int'(pwmOut), 1);
    enable = 1'b0;
    @(negedge clk);
    check(!pwmOut && !periodStrobe, "R8 drop", int'({pwmOut, periodStrobe}), 0);
    begin
      int seen = 0;
      for (int i = 0; i < 80; i++) begin
        @(negedge clk);
        seen += int'(pwmOut) + int'(periodStrobe);
      end
      check(seen == 0, "R8 hold low", seen, 0);
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule